// File: doc/BRIEF.md
# PIO Register Access Sequencer

This block is the host side of an 8-bit register port on an ATA-style device driven with programmed I/O strobes. A requester hands it one access at a time: a 5-bit device address, a read/write flag and, for writes, a data byte. The block then walks the device bus through address setup, strobe active, post-strobe hold and recovery phases. When the strobe is negated it returns a one-cycle done pulse and, on reads, the captured byte.

Every phase length is a whole number of system clock cycles. These lengths are computed at elaboration from nanosecond minimums and a clock-period parameter. Each minimum is divided by the period and rounded up, with a floor of one cycle. The strobe-active time plus the strobe-inactive time must reach a full access-cycle minimum that is larger than the active and recovery minimums added together. Any shortfall is added to the recovery phase. Recovery is also kept long enough for the device to release the data bus after a read, and for the address and write-data hold after negation.

Requests use a valid/ready handshake. Ready falls on acceptance and rises only when recovery has ended. A new access therefore cannot break the recovery or full-cycle minimum.

Top module: `pio_reg_seq`

## Requirements
- R1: After reset, and whenever `req_ready` is high, both chip selects are high (`dev_cs_n` = 2'b11), `dev_rd_n` and `dev_wr_n` are high, `dd_oe` is low and `rsp_done` is low.
- R2: The strobe of an accepted request falls exactly SETUP_C cycles after the address and chip selects are applied. Address and chip selects appear in the first cycle after the acceptance edge. SETUP_C is ceil(25 ns / period) with a floor of 1, which is 3 at 10 ns.
- R3: The strobe stays low for exactly ACT_C cycles. ACT_C is the larger of ceil(70 ns / period) and ceil(20 ns / period), which is 7 at 10 ns.
- R4: `req_ready` returns exactly REC_C cycles after the strobe rises. REC_C is the largest of three values: ceil(25 ns / period) plus any shortfall of ACT_C + ceil(25 ns / period) against ceil(120 ns / period); ceil(30 ns / period); and HOLD_C + 1. REC_C is 5 at 10 ns, so ACT_C + REC_C = 12 cycles = 120 ns.
- R5: Address and chip selects stay constant from application until HOLD_C cycles after the strobe rises, then the chip selects return high. HOLD_C is the larger of ceil(10 ns / period) for address hold and ceil(10 ns / period) for write-data hold, which is 1 at 10 ns.
- R6: A write (`req_wr` = 1) pulses only `dev_wr_n`. `dd_oe` is high and `dd_out` equals the request data for the whole strobe-low time, and both are held until the chip selects return high.
- R7: A read (`req_wr` = 0) pulses only `dev_rd_n`, never raises `dd_oe`, and loads `rsp_rdata` with `dd_in` sampled at the clock edge that negates the read strobe. `rsp_rdata` holds that value until the next read.
- R8: `req_valid` asserted while `req_ready` is low is ignored: it starts no access and leaves the device registers unwritten.
- R9: Address bits [4:3] of `req_addr` are chip-select enables, so `dev_cs_n` = ~`req_addr[4:3]`. Bits [2:0] drive `dev_da`.
- R10: `rsp_done` is a single-cycle pulse per access, high in the first cycle that the strobe is back high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_wr | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | [4:3] chip-select enables, [2:0] register address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last captured read byte |
| dev_cs_n | output | 2 | Active-low chip selects |
| dev_da | output | 3 | Device register address |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dd_out | output | 8 | Host data toward device |
| dd_oe | output | 1 | Host data driver enable |
| dd_in | input | 8 | Data bus from device |

## Verification
The bench keeps the default 10 ns clock period. At that period the phases come out at 3 setup, 7 active, 1 hold and 5 recovery cycles. The recovery minimum alone would give 3 cycles, so the stretch that fills the 120 ns cycle is actually exercised. The 30 ns bus-release window is also shorter than the stretched recovery. These values make the exact setup, width, hold and ready-return cycles observable for every random access. They also leave room to poke `req_valid` during a busy access and release it before ready returns.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned REG_AW = 3;
    localparam int unsigned SEL_W  = 2;

    typedef struct packed {
        logic              wr;
        logic [SEL_W-1:0]  sel;
        logic [REG_AW-1:0] reg_a;
        logic [DATA_W-1:0] wdata;
    } pio_req_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned r;
        r = (ns + clk_ns - 1) / clk_ns;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned shortfall(input int unsigned need, input int unsigned have);
        return (need > have) ? need - have : 0;
    endfunction

endpackage

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
    import pio_pkg::*;
#(
    parameter int unsigned SETUP_C = 3,
    parameter int unsigned ACT_C   = 7,
    parameter int unsigned HOLD_C  = 1,
    parameter int unsigned TAIL_C  = 4,
    parameter int unsigned CNT_W   = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   last
);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_C - 1);
    localparam logic [CNT_W-1:0] LD_ACT   = CNT_W'(ACT_C - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_C - 1);
    localparam logic [CNT_W-1:0] LD_TAIL  = CNT_W'(TAIL_C - 1);

    logic [CNT_W-1:0] cnt;

    assign last = (phase != PH_IDLE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= LD_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_ACTIVE;
                        cnt   <= LD_ACT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= LD_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_RECOV;
                        cnt   <= LD_TAIL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pio_bus_drv.sv
module pio_bus_drv
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  pio_req_t          req,
    input  phase_e            phase,
    input  logic              last,
    output logic [SEL_W-1:0]  cs_n,
    output logic [REG_AW-1:0] da,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              oe,
    output logic              ready,
    output logic              wr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= '1;
            da    <= '0;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            dout  <= '0;
            oe    <= 1'b0;
            ready <= 1'b1;
            wr_q  <= 1'b0;
        end else begin
            if (start) begin
                cs_n  <= ~req.sel;
                da    <= req.reg_a;
                dout  <= req.wdata;
                wr_q  <= req.wr;
                ready <= 1'b0;
            end
            if (last) begin
                case (phase)
                    PH_SETUP: begin
                        if (wr_q) begin
                            wr_n <= 1'b0;
                            oe   <= 1'b1;
                        end else begin
                            rd_n <= 1'b0;
                        end
                    end
                    PH_ACTIVE: begin
                        rd_n <= 1'b1;
                        wr_n <= 1'b1;
                    end
                    PH_HOLD: begin
                        cs_n <= '1;
                        oe   <= 1'b0;
                    end
                    PH_RECOV: ready <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pio_rd_capture.sv
module pio_rd_capture
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              last,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic negate;
    assign negate = last && (phase == PH_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= negate;
            if (negate && !wr_q) rdata <= din;
        end
    end

endmodule

// File: rtl/pio_reg_seq.sv
module pio_reg_seq
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned T_ASU_NS   = 25,
    parameter int unsigned T_ACT_NS   = 70,
    parameter int unsigned T_REC_NS   = 25,
    parameter int unsigned T_CYC_NS   = 120,
    parameter int unsigned T_WSU_NS   = 20,
    parameter int unsigned T_WDH_NS   = 10,
    parameter int unsigned T_AH_NS    = 10,
    parameter int unsigned T_REL_NS   = 30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_wr,
    input  logic [4:0]  req_addr,
    input  logic [7:0]  req_wdata,
    output logic        rsp_done,
    output logic [7:0]  rsp_rdata,
    output logic [1:0]  dev_cs_n,
    output logic [2:0]  dev_da,
    output logic        dev_rd_n,
    output logic        dev_wr_n,
    output logic [7:0]  dd_out,
    output logic        dd_oe,
    input  logic [7:0]  dd_in
);
    localparam int unsigned SETUP_C   = ns_to_cyc(T_ASU_NS, CLK_NS);
    localparam int unsigned ACT_C     = umax(ns_to_cyc(T_ACT_NS, CLK_NS), ns_to_cyc(T_WSU_NS, CLK_NS));
    localparam int unsigned REC_MIN_C = ns_to_cyc(T_REC_NS, CLK_NS);
    localparam int unsigned CYC_C     = ns_to_cyc(T_CYC_NS, CLK_NS);
    localparam int unsigned HOLD_C    = umax(ns_to_cyc(T_AH_NS, CLK_NS), ns_to_cyc(T_WDH_NS, CLK_NS));
    localparam int unsigned REL_C     = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int unsigned STRETCH_C = shortfall(CYC_C, ACT_C + REC_MIN_C);
    localparam int unsigned REC_C     = umax(REC_MIN_C + STRETCH_C, umax(REL_C, HOLD_C + 1));
    localparam int unsigned TAIL_C    = REC_C - HOLD_C;
    localparam int unsigned MAX_C     = umax(umax(SETUP_C, ACT_C), umax(HOLD_C, TAIL_C));
    localparam int unsigned CNT_W     = $clog2(MAX_C + 1);

    pio_req_t req;
    phase_e   phase;
    logic     last;
    logic     start;
    logic     wr_q;

    assign req   = '{wr: req_wr, sel: req_addr[4:3], reg_a: req_addr[2:0], wdata: req_wdata};
    assign start = req_valid && req_ready;

    pio_phase_ctrl #(
        .SETUP_C (SETUP_C),
        .ACT_C   (ACT_C),
        .HOLD_C  (HOLD_C),
        .TAIL_C  (TAIL_C),
        .CNT_W   (CNT_W)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .last  (last)
    );

    pio_bus_drv u_bus (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .req   (req),
        .phase (phase),
        .last  (last),
        .cs_n  (dev_cs_n),
        .da    (dev_da),
        .rd_n  (dev_rd_n),
        .wr_n  (dev_wr_n),
        .dout  (dd_out),
        .oe    (dd_oe),
        .ready (req_ready),
        .wr_q  (wr_q)
    );

    pio_rd_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (last),
        .wr_q  (wr_q),
        .din   (dd_in),
        .done  (rsp_done),
        .rdata (rsp_rdata)
    );

endmodule

// File: rtl/pio_reg_seq_chk.sv
module pio_reg_seq_chk #(
    parameter int unsigned ACT_C = 7,
    parameter int unsigned REC_C = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_done,
    input logic [1:0] dev_cs_n,
    input logic [2:0] dev_da,
    input logic       dev_rd_n,
    input logic       dev_wr_n,
    input logic       dd_oe
);
    logic       strobe_hi;
    logic [7:0] low_cnt;
    logic [7:0] hi_cnt;

    assign strobe_hi = dev_rd_n && dev_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            low_cnt <= strobe_hi ? 8'd0 : low_cnt + 8'd1;
            if (!strobe_hi) hi_cnt <= '0;
            else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dev_cs_n == 2'b11 && strobe_hi && !dd_oe && !rsp_done)); // R1

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_hi) |-> (low_cnt == 8'(ACT_C))); // R3

    AST_RECOVERY_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> (hi_cnt == 8'(REC_C))); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!strobe_hi && !$rose(dev_rd_n || dev_wr_n)) |-> ($stable(dev_da) && $stable(dev_cs_n))); // R5

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!dev_rd_n && !dev_wr_n)); // R6

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !dev_rd_n |-> !dd_oe); // R7

    AST_DONE_AT_NEGATION: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ($rose(dev_rd_n) || $rose(dev_wr_n))); // R10

endmodule

bind pio_reg_seq pio_reg_seq_chk #(.ACT_C(ACT_C), .REC_C(REC_C)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .dev_cs_n  (dev_cs_n),
    .dev_da    (dev_da),
    .dev_rd_n  (dev_rd_n),
    .dev_wr_n  (dev_wr_n),
    .dd_oe     (dd_oe)
);

// File: tb/sim_pio_reg_seq.sv
module sim_pio_reg_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_wr = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic [1:0] dev_cs_n;
    logic [2:0] dev_da;
    logic       dev_rd_n;
    logic       dev_wr_n;
    logic [7:0] dd_out;
    logic       dd_oe;
    logic [7:0] dd_in;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] dev_mem [32];
    logic [7:0] exp_mem [32];
    logic       wr_seen_low = 1'b0;

    always #5 clk = ~clk;

    pio_reg_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dev_cs_n(dev_cs_n),
        .dev_da(dev_da), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in)
    );

    // Device model: drives stored byte while read strobe is low, stores on write-strobe rise
    assign dd_in = (!dev_rd_n) ? dev_mem[{~dev_cs_n, dev_da}] : 8'hEE;

    always @(negedge clk) begin
        if (wr_seen_low && dev_wr_n && dd_oe) dev_mem[{~dev_cs_n, dev_da}] <= dd_out;
        wr_seen_low <= !dev_wr_n;
    end

    function automatic int cyc(input int ns);
        int r;
        r = (ns + 9) / 10;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int E_SU, E_ACT, E_HOLD, E_REC;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_access(input bit wr, input logic [4:0] a, input logic [7:0] wd, input bit poke);
        int  k_fall = -1, k_rise = -1, k_csup = -1, k_rdy = -1, done_k = -1, done_cnt = 0;
        bit  addr_bad = 0, wdat_bad = 0, oe_bad = 0, other_bad = 0, hold_bad = 0;
        bit  s_low;
        logic [7:0] exp_rd;
        exp_rd = exp_mem[a];
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            if (poke && k >= 2 && k <= E_SU + E_ACT + 2) begin
                req_valid = 1'b1; req_wr = 1'b1; req_addr = 5'h1F; req_wdata = 8'hFF;
            end else begin
                req_valid = 1'b0;
            end
            s_low = wr ? !dev_wr_n : !dev_rd_n;
            if (s_low && k_fall < 0) k_fall = k;
            if (!s_low && k_fall >= 0 && k_rise < 0) k_rise = k;
            if (dev_cs_n == 2'b11 && k_csup < 0 && k_rise >= 0) k_csup = k;
            if (req_ready && k_rdy < 0) k_rdy = k;
            if (rsp_done) begin done_cnt++; done_k = k; end
            if (k_csup < 0 && (dev_cs_n != ~a[4:3] || dev_da != a[2:0])) addr_bad = 1;
            if (wr && k_fall >= 0 && k_csup < 0 && (!dd_oe || dd_out != wd)) wdat_bad = 1;
            if (!wr && dd_oe) oe_bad = 1;
            if (wr ? !dev_rd_n : !dev_wr_n) other_bad = 1;
            if (k_rise >= 0 && k_csup < 0 && !s_low && k - k_rise >= E_HOLD) hold_bad = 1;
            if (k_rdy >= 0) break;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(k_fall == E_SU + 1, "R2 setup", k_fall, E_SU + 1);
        chk(k_rise - k_fall == E_ACT, "R3 width", k_rise - k_fall, E_ACT);
        chk(k_rdy - k_rise == E_REC, "R4 recovery", k_rdy - k_rise, E_REC);
        chk(E_ACT + E_REC >= 12, "R4 cycle", E_ACT + E_REC, 12);
        chk(k_csup - k_rise == E_HOLD && !hold_bad, "R5 hold", k_csup - k_rise, E_HOLD);
        chk(!addr_bad, "R9 address map", addr_bad, 0);
        chk(!other_bad, wr ? "R6 strobe select" : "R7 strobe select", other_bad, 0);
        chk(done_cnt == 1 && done_k == k_rise, "R10 done", done_k, k_rise);
        if (wr) begin
            chk(!wdat_bad, "R6 write data", wdat_bad, 0);
            exp_mem[a] = wd;
        end else begin
            chk(!oe_bad, "R7 no drive", oe_bad, 0);
            chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [4:0] a;
        logic [7:0] d;
        bit idle_bad;
        E_SU   = cyc(25);
        E_ACT  = imax(cyc(70), cyc(20));
        E_HOLD = imax(cyc(10), cyc(10));
        E_REC  = imax(cyc(25) + imax(0, cyc(120) - E_ACT - cyc(25)), imax(cyc(30), E_HOLD + 1));
        for (int i = 0; i < 32; i++) begin
            dev_mem[i] = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
        seed = 32'd7;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dd_oe && req_ready && !rsp_done,
            "R1 state in reset", {dev_cs_n, dev_rd_n, dev_wr_n, dd_oe, req_ready}, 6'b111101);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dd_oe && req_ready && !rsp_done,
            "R1 idle after reset", {dev_cs_n, dev_rd_n, dev_wr_n, dd_oe, req_ready}, 6'b111101);

        // directed: write then read back, both chip selects
        run_access(1'b1, 5'b01_010, 8'hA5, 1'b0);
        run_access(1'b0, 5'b01_010, 8'h00, 1'b0);
        run_access(1'b1, 5'b10_111, 8'h3C, 1'b0);
        run_access(1'b0, 5'b10_111, 8'h00, 1'b0);
        run_access(1'b0, 5'b10_000, 8'h00, 1'b0);

        // R8: requests presented while busy are ignored
        run_access(1'b0, 5'b01_001, 8'h00, 1'b1);
        idle_bad = 0;
        for (int k = 0; k < 12; k++) begin
            if (!dev_rd_n || !dev_wr_n || dev_cs_n != 2'b11 || !req_ready) idle_bad = 1;
            @(negedge clk);
        end
        chk(!idle_bad, "R8 no access started while busy", idle_bad, 0);
        run_access(1'b0, 5'h1F, 8'h00, 1'b0);
        chk(rsp_rdata == 8'(31 * 37 + 11), "R8 register untouched", rsp_rdata, 8'(31 * 37 + 11));

        // R1: idle output state between accesses
        chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dd_oe,
            "R1 idle between accesses", {dev_cs_n, dev_rd_n, dev_wr_n, dd_oe}, 5'b11110);

        // random accesses
        for (int n = 0; n < 60; n++) begin
            a = {($urandom % 2 == 0) ? 2'b01 : 2'b10, 3'($urandom)};
            d = 8'($urandom);
            run_access(1'($urandom % 2), a, d, 1'b0);
            if ($urandom % 3 == 0) repeat ($urandom % 4) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule